// File: doc/BRIEF.md
# Raster Line Compare Interrupt Generator

This block tracks the beam position of a video timing generator with two counters: a cycle counter within the line (numbered from 1) and a line counter within the frame (numbered from 0). A 9-bit compare register selects one line. When the beam reaches that line, the block sets a sticky interrupt flag at a fixed cycle of the line. The interrupt output is the flag gated by an enable bit.

The fixed cycle is cycle 1 on every line except line 0, where the flag is set at cycle 2. Line 0 still runs the full number of cycles. A small 4-entry register bus gives software access to the compare value and to the current line, and lets it clear the flag by writing a one to it.

An elaboration parameter picks the frame geometry. The 50 Hz setting has 63 cycles per line and 312 lines, which is 19656 cycles per frame. The 60 Hz setting has 65 cycles per line and 263 lines, which is 17095 cycles per frame.

Top module: `raster_irq_gen`

## Requirements
- R1: While reset is held, the beam sits at cycle 1 of line 0. The compare value is 0x1FF, the flag and the enable are 0, and `irq` is 0.
- R2: `beam_cycle` counts 1, 2, … up to the line length (63 in the default 50 Hz mode) and then returns to 1. Every line has this same length, line 0 included.
- R3: `beam_line` advances by one when the cycle counter wraps. After the last line (311 in the default mode) it returns to 0.
- R4: On a nonzero line equal to the compare value, the flag (address 3, bit 0) is still 0 while the beam shows cycle 1. It reads 1 from the following clock onward.
- R5: On line 0 with compare value 0, nothing happens at cycle 1. The flag is still 0 while the beam shows cycle 2 and reads 1 from the next clock.
- R6: A write to address 0 sets compare bits 7:0. A write to address 1 bit 0 sets compare bit 8. Reads of those locations return the stored bits.
- R7: A read of address 2 returns current line bits 7:0. A read of address 1 bit 7 returns current line bit 8.
- R8: A write to address 3 with bit 0 set clears the flag. With bit 0 clear, the flag is left unchanged. Otherwise the flag stays set.
- R9: Address 3 bit 1 is the enable, readable and writable. `irq` is high exactly when both the flag and the enable are 1.
- R10: The compare value is sampled only at the firing cycle of each line. A compare write that matches the current line after that cycle does not set the flag until the line comes round again in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| beam_cycle | output | 7 | Current cycle within the line, starting at 1 |
| beam_line | output | 9 | Current line within the frame |
| irq | output | 1 | Flag AND enable |

## Verification
The beam outputs move on every clock edge. The flag, and with it `irq`, rises one clock after the beam outputs first show the firing cycle. The bench samples at the falling edge, waits until the beam shows the compare line at its firing cycle, expects a clear flag there, and expects the set flag at the next falling edge. Register writes take effect at the next rising edge. Reads are combinational, so read checks are sampled a fraction of a cycle after the address is set. The compare-write and line-0 cases are timed against the beam outputs, never against internal state.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef enum logic [0:0] {
    TIMING_50HZ = 1'b0,
    TIMING_60HZ = 1'b1
  } timing_e;

  localparam int CYC_W  = 7;
  localparam int LINE_W = 9;
  localparam int DATA_W = 8;

  // register addresses
  localparam logic [1:0] ADDR_CMP_LO  = 2'd0;
  localparam logic [1:0] ADDR_CTRL    = 2'd1;
  localparam logic [1:0] ADDR_LINE_LO = 2'd2;
  localparam logic [1:0] ADDR_IRQ     = 2'd3;

  // bit positions inside the control and interrupt registers
  localparam int CTRL_CMP_HI_BIT  = 0;
  localparam int CTRL_LINE_HI_BIT = 7;
  localparam int IRQ_FLAG_BIT     = 0;
  localparam int IRQ_EN_BIT       = 1;

  localparam logic [LINE_W-1:0] CMP_RESET = 9'h1FF;

  function automatic int cycles_per_line(timing_e t);
    return (t == TIMING_60HZ) ? 65 : 63;
  endfunction

  function automatic int lines_per_frame(timing_e t);
    return (t == TIMING_60HZ) ? 263 : 312;
  endfunction

  // cycle of a line at which a compare match is taken
  function automatic logic [CYC_W-1:0] fire_cycle(logic [LINE_W-1:0] line);
    return (line == '0) ? CYC_W'(2) : CYC_W'(1);
  endfunction

endpackage

// File: rtl/raster_beam_counter.sv
module raster_beam_counter
  import raster_pkg::*;
#(
  parameter int CPL = 63,
  parameter int LPF = 312
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [CYC_W-1:0]  cycle,
  output logic [LINE_W-1:0] line,
  output logic              line_end,
  output logic              frame_end
);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(CPL);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LPF - 1);

  logic [CYC_W-1:0]  cycle_q;
  logic [LINE_W-1:0] line_q;

  assign line_end  = (cycle_q == CYC_LAST);
  assign frame_end = line_end && (line_q == LINE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle_q <= CYC_W'(1);
      line_q  <= '0;
    end else begin
      if (line_end) begin
        cycle_q <= CYC_W'(1);
        line_q  <= frame_end ? '0 : line_q + LINE_W'(1);
      end else begin
        cycle_q <= cycle_q + CYC_W'(1);
      end
    end
  end

  assign cycle = cycle_q;
  assign line  = line_q;
endmodule

// File: rtl/raster_compare.sv
module raster_compare
  import raster_pkg::*;
(
  input  logic [CYC_W-1:0]  cycle,
  input  logic [LINE_W-1:0] line,
  input  logic [LINE_W-1:0] cmp,
  output logic              hit
);
  // match is only taken at the line's firing cycle
  logic at_fire;
  assign at_fire = (cycle == fire_cycle(line));
  assign hit     = at_fire && (line == cmp);
endmodule

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              hit,
  input  logic [LINE_W-1:0] line,
  output logic [LINE_W-1:0] cmp,
  output logic              flag,
  output logic              enable,
  output logic              flag_clr,
  output logic              irq
);
  logic [LINE_W-1:0] cmp_q;
  logic              flag_q;
  logic              en_q;
  logic              wr_cmp_lo, wr_ctrl, wr_irq;

  assign wr_cmp_lo = bus_wr && (bus_addr == ADDR_CMP_LO);
  assign wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_irq    = bus_wr && (bus_addr == ADDR_IRQ);
  assign flag_clr  = wr_irq && bus_wdata[IRQ_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= CMP_RESET;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_cmp_lo) cmp_q[7:0] <= bus_wdata;
      if (wr_ctrl)   cmp_q[8]   <= bus_wdata[CTRL_CMP_HI_BIT];
      if (wr_irq)    en_q       <= bus_wdata[IRQ_EN_BIT];
      // a new match wins over a clear in the same cycle
      if (hit)           flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CMP_LO:  bus_rdata = cmp_q[7:0];
      ADDR_CTRL: begin
        bus_rdata[CTRL_CMP_HI_BIT]  = cmp_q[8];
        bus_rdata[CTRL_LINE_HI_BIT] = line[8];
      end
      ADDR_LINE_LO: bus_rdata = line[7:0];
      default: begin
        bus_rdata[IRQ_FLAG_BIT] = flag_q;
        bus_rdata[IRQ_EN_BIT]   = en_q;
      end
    endcase
  end

  assign cmp    = cmp_q;
  assign flag   = flag_q;
  assign enable = en_q;
  assign irq    = flag_q & en_q;
endmodule

// File: rtl/raster_irq_gen.sv
module raster_irq_gen
  import raster_pkg::*;
#(
  parameter timing_e TIMING = TIMING_50HZ
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CYC_W-1:0]  beam_cycle,
  output logic [LINE_W-1:0] beam_line,
  output logic              irq
);
  localparam int CPL = cycles_per_line(TIMING);
  localparam int LPF = lines_per_frame(TIMING);

  // named internal events, observed by the bound checker
  logic              line_end;
  logic              frame_end;
  logic              raster_hit;
  logic [LINE_W-1:0] cmp_val;
  logic              irq_flag;
  logic              irq_en;
  logic              flag_clr;

  raster_beam_counter #(.CPL(CPL), .LPF(LPF)) u_beam (
    .clk       (clk),
    .rst_n     (rst_n),
    .cycle     (beam_cycle),
    .line      (beam_line),
    .line_end  (line_end),
    .frame_end (frame_end)
  );

  raster_compare u_cmp (
    .cycle (beam_cycle),
    .line  (beam_line),
    .cmp   (cmp_val),
    .hit   (raster_hit)
  );

  raster_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hit       (raster_hit),
    .line      (beam_line),
    .cmp       (cmp_val),
    .flag      (irq_flag),
    .enable    (irq_en),
    .flag_clr  (flag_clr),
    .irq       (irq)
  );
endmodule

// File: rtl/raster_irq_chk.sv
module raster_irq_chk
  import raster_pkg::*;
#(
  parameter int CPL = 63,
  parameter int LPF = 312
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CYC_W-1:0]  beam_cycle,
  input logic [LINE_W-1:0] beam_line,
  input logic              hit,
  input logic              flag,
  input logic              enable,
  input logic              flag_clr,
  input logic              irq
);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(CPL);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LPF - 1);

  // R2
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_cycle == CYC_LAST) |=> (beam_cycle == CYC_W'(1)));

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_cycle == CYC_LAST && beam_line != LINE_LAST) |=> (beam_line == $past(beam_line) + LINE_W'(1)));

  // R3
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beam_cycle == CYC_LAST && beam_line == LINE_LAST) |=> (beam_line == '0));

  // R4
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));

  // R5
  line0_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && beam_line == '0) |-> (beam_cycle == CYC_W'(2)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !enable) |-> !irq);
endmodule

bind raster_irq_gen raster_irq_chk #(.CPL(CPL), .LPF(LPF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .beam_cycle (beam_cycle),
  .beam_line  (beam_line),
  .hit        (raster_hit),
  .flag       (irq_flag),
  .enable     (irq_en),
  .flag_clr   (flag_clr),
  .irq        (irq)
);

// File: tb/sim_raster_irq_gen.sv
module sim_raster_irq_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [6:0] beam_cycle;
  logic [8:0] beam_line;
  logic       irq;

  int n_checks = 0;
  int n_fails  = 0;
  int n_clk    = 0;

  always #4 clk = ~clk;   // 125 MHz

  raster_irq_gen u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .beam_cycle(beam_cycle),
    .beam_line(beam_line), .irq(irq)
  );

  // {enable, compare[8:0]}, lines in rising order, line 0 last
  localparam logic [9:0] VEC [7] = '{10'h203, 10'h20A, 10'h064, 10'h2FF,
                                     10'h300, 10'h337, 10'h200};

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_beam(input int l, input int c);
    while (!(beam_line == 9'(l) && beam_cycle == 7'(c))) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", n_clk);
      finish_run();
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 cycle", int'(beam_cycle), 1);
    check("R1 line", int'(beam_line), 0);
    check("R1 irq", int'(irq), 0);
    bus_read(2'd0, rd); check("R1 cmp lo", int'(rd), 8'hFF);
    bus_read(2'd1, rd); check("R1 cmp hi", int'(rd[0]), 1);
    bus_read(2'd3, rd); check("R1 flag/en", int'(rd), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk: R4 nonzero lines, R5 line 0, R9 enable
    for (int i = 0; i < 7; i++) begin
      automatic logic [8:0] cmpv = VEC[i][8:0];
      automatic logic       env  = VEC[i][9];
      automatic int         fc   = (cmpv == 9'd0) ? 2 : 1;
      bus_write(2'd1, {7'd0, cmpv[8]});
      bus_write(2'd0, cmpv[7:0]);
      bus_write(2'd3, {6'd0, env, 1'b1});
      wait_beam(int'(cmpv), fc);
      bus_read(2'd3, rd);
      check((cmpv == 0) ? "R5 flag before" : "R4 flag before", int'(rd[0]), 0);
      check("R9 irq before", int'(irq), 0);
      @(negedge clk);
      bus_read(2'd3, rd);
      check((cmpv == 0) ? "R5 flag set" : "R4 flag set", int'(rd[0]), 1);
      check("R9 irq gated", int'(irq), int'(env));
    end

    // R8 write-one-to-clear, R9 masking (flag set, enable 1 here)
    bus_write(2'd3, 8'h02);
    bus_read(2'd3, rd); check("R8 zero write keeps flag", int'(rd[0]), 1);
    check("R9 irq on", int'(irq), 1);
    bus_write(2'd3, 8'h00);
    bus_read(2'd3, rd); check("R9 enable off", int'(rd[1]), 0);
    check("R9 irq masked", int'(irq), 0);
    check("R8 flag held", int'(rd[0]), 1);
    bus_write(2'd3, 8'h01);
    bus_read(2'd3, rd); check("R8 flag cleared", int'(rd[0]), 0);

    // R6 compare readback (346 never matches in this geometry)
    bus_write(2'd1, 8'h01);
    bus_write(2'd0, 8'h5A);
    bus_read(2'd0, rd); check("R6 cmp lo", int'(rd), 8'h5A);
    bus_read(2'd1, rd); check("R6 cmp hi", int'(rd[0]), 1);

    // R2 line 0 full length
    wait_beam(0, 63);
    @(negedge clk);
    check("R2 line0 length cycle", int'(beam_cycle), 1);
    check("R2 line0 length line", int'(beam_line), 1);

    // R7 current line readback
    wait_beam(300, 5);
    bus_read(2'd2, rd); check("R7 line lo", int'(rd), 44);
    bus_read(2'd1, rd); check("R7 line hi", int'(rd[7]), 1);

    // R3 frame wrap
    wait_beam(311, 63);
    @(negedge clk);
    check("R3 wrap line", int'(beam_line), 0);
    check("R3 wrap cycle", int'(beam_cycle), 1);

    // R10 compare written mid-line to the current line
    wait_beam(20, 30);
    bus_write(2'd1, 8'h00);
    bus_write(2'd0, 8'd20);
    bus_write(2'd3, 8'h03);
    bus_read(2'd3, rd); check("R10 no fire mid-line", int'(rd[0]), 0);
    wait_beam(21, 1);
    bus_read(2'd3, rd); check("R10 no fire same line", int'(rd[0]), 0);
    wait_beam(20, 1);
    bus_read(2'd3, rd); check("R10 not yet", int'(rd[0]), 0);
    @(negedge clk);
    bus_read(2'd3, rd); check("R10 fires next frame", int'(rd[0]), 1);
    check("R10 irq", int'(irq), 1);

    finish_run();
  end
endmodule